// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a register-mapped serial master for a processor bus. Software sets the frame width, the clock polarity and phase, and a two-stage bit-rate divider. It then writes frames to a transmit queue. The shift engine takes one frame at a time from that queue. It drives the frame out most significant bit first while it captures the same number of bits from the serial input, and it places each captured frame in a receive queue. Software reads that queue through the same data address.

Each queue holds eight frames. Three interrupt sources share a single request line: receive queue at least half full, transmit queue at most half full, and receive overrun. An overrun happens when a frame completes while the receive queue is full. That frame is discarded and a sticky flag is set, and any write to the identify address clears the flag. In loopback mode the serial output feeds the capture path inside the block, so the port can be tested without a device attached. Chip selects are driven outside this block.

Top module: `ssp_top`

## Requirements
- R1: After reset, all control registers read zero, the status register reads 0x03, the identify register reads zero, `spi_sck` is low and `irq` is low.
- R2: Register map (byte address, 32-bit spacing, bits [1:0] must be zero):
  - 0x00 control 0: [3:0] size, [6] phase, [7] polarity, [15:8] rate. Bits [5:4] read as zero.
  - 0x04 control 1: [0] rx interrupt enable, [1] tx interrupt enable, [2] overrun interrupt enable, [3] loopback, [4] port enable, [5] slave select (stored only), [6] slave output disable (stored only).
  - 0x08 data.
  - 0x0C status.
  - 0x10 prescale (8 bits).
  - 0x14 identify/clear.
  - The control and prescale registers read back what was written.
- R3: The frame width is N = size+1 for a size of 3..15, and 4 for a smaller size. Each queued frame is sent MSB first as N bits and yields exactly one received frame of N bits, with the upper bits zero. Transmit data is masked to N bits.
- R4: When no frame is shifting, `spi_sck` equals the polarity bit. With phase 0, the input is sampled on the leading clock edge and the output changes on the trailing edge. With phase 1, the output changes on the leading edge (except the first) and the input is sampled on the trailing edge.
- R5: Each half period of `spi_sck` lasts max(prescale/2,1)×(rate+1) clock cycles, and a frame has 2N clock edges.
- R6: If a frame completes while the receive queue holds 8 frames, the frame is discarded, the queue contents are unchanged, and the overrun flag is set. The flag reads at identify bit 2 when its enable is set.
- R7: A write of any value to 0x14 clears the overrun flag.
- R8: Identify register:
  - bit 0 = rx enable AND receive queue holds ≥4 frames.
  - bit 1 = tx enable AND transmit queue holds ≤4 frames.
  - bit 2 = overrun enable AND overrun flag.
  - `irq` is the OR of the three bits.
- R9: Status bits: [0] transmit queue empty, [1] transmit queue not full, [2] receive queue not empty, [3] receive queue full, [4] busy (frame shifting or transmit queue not empty).
- R10: While the enable bit is clear, no frame starts, queued transmit frames are kept, and `spi_sck` does not toggle.
- R11: In loopback mode the received bits come from the block's own serial output, and `spi_miso` has no effect.
- R12: A write to the data address while the transmit queue holds 8 frames is dropped. Frames leave each queue in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt request |

## Verification
Two situations are hard to reach from the ports: a full receive queue while a frame is still completing, and a transmit queue held at an exact fill level. For the first, the bench runs eight frames in loopback without reading them and then queues a ninth. For the second, the bench fills the transmit queue with the port disabled, which stops the queue from draining, and probes the thresholds one frame at a time. The clock-mode checks use a bench slave that follows `spi_sck` edges. It is run in all four modes with random widths and rates, and it compares what it captured against what the master was given.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int DATA_W        = 16;
    localparam int FIFO_DEPTH_DEF = 8;

    // word index = byte address [4:2]
    localparam logic [2:0] IDX_CTRL0 = 3'd0;
    localparam logic [2:0] IDX_CTRL1 = 3'd1;
    localparam logic [2:0] IDX_DATA  = 3'd2;
    localparam logic [2:0] IDX_STAT  = 3'd3;
    localparam logic [2:0] IDX_PRE   = 3'd4;
    localparam logic [2:0] IDX_IDENT = 3'd5;

    typedef struct packed {
        logic [7:0] rate;
        logic       cpol;   // bit 7
        logic       cpha;   // bit 6
        logic [3:0] size;   // bits per frame minus one
    } ctrl0_t;

    typedef struct packed {
        logic sod;
        logic ms;
        logic en;
        logic lbm;
        logic rorie;
        logic tie;
        logic rie;
    } ctrl1_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_DONE} eng_state_t;

    function automatic logic [4:0] frame_bits(input logic [3:0] sz);
        return (sz < 4'd3) ? 5'd4 : ({1'b0, sz} + 5'd1);
    endfunction

    function automatic logic [DATA_W-1:0] frame_mask(input logic [4:0] n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++)
            if (i < int'(n)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] half_period(input logic [7:0] pre, input logic [7:0] rate);
        logic [6:0] hp;
        hp = (pre[7:1] == 7'd0) ? 7'd1 : pre[7:1];
        return 16'(hp) * (16'(rate) + 16'd1);
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + PW'(1);
            if (do_pop)  rp <= rp + PW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [4:0]    nbits,
    input  logic [15:0]   half,
    input  logic          start,
    input  logic [DW-1:0] tx_frame,
    input  logic          din,
    output logic          sck,
    output logic          dout,
    output logic          busy,
    output logic          idle,
    output logic          rx_valid,
    output logic [DW-1:0] rx_frame
);
    eng_state_t    st;
    logic [15:0]   hcnt;
    logic [5:0]    edg;
    logic [5:0]    last_edg;
    logic          ph;
    logic [DW-1:0] txs, rxs;

    assign last_edg = {nbits, 1'b0} - 6'd1;
    assign sck      = ph ^ cpol;
    assign dout     = txs[4'(nbits - 5'd1)];
    assign busy     = (st != ENG_IDLE);
    assign idle     = (st == ENG_IDLE);
    assign rx_valid = (st == ENG_DONE);
    assign rx_frame = rxs;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= ENG_IDLE;
            hcnt <= '0;
            edg  <= '0;
            ph   <= 1'b0;
            txs  <= '0;
            rxs  <= '0;
        end else begin
            case (st)
                ENG_IDLE: if (start) begin
                    txs  <= tx_frame;
                    rxs  <= '0;
                    hcnt <= '0;
                    edg  <= '0;
                    st   <= ENG_SHIFT;
                end
                ENG_SHIFT: begin
                    if (hcnt == half - 16'd1) begin
                        hcnt <= '0;
                        ph   <= ~ph;
                        edg  <= edg + 6'd1;
                        if (edg[0] == cpha)
                            rxs <= {rxs[DW-2:0], din};
                        else if (!(cpha && edg == 6'd0))
                            txs <= {txs[DW-2:0], 1'b0};
                        if (edg == last_edg) st <= ENG_DONE;
                    end else begin
                        hcnt <= hcnt + 16'd1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_top.sv
module ssp_top
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = FIFO_DEPTH_DEF,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        irq
);
    ctrl0_t      c0_q;
    ctrl1_t      c1_q;
    logic [7:0]  pre_q;
    logic        ror_q;

    logic        acc, wr, rd;
    logic [2:0]  widx;
    logic [4:0]  nbits;
    logic [15:0] fmask, half;

    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [15:0] tx_head, rx_head, rx_frame;
    logic        eng_busy, eng_idle, rx_valid, dout, din, start;
    logic        rx_int, tx_int, ror_int, ror_set, clr_wr;

    assign acc   = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr    = acc && bus_wr;
    assign rd    = acc && !bus_wr;
    assign widx  = bus_addr[4:2];
    assign nbits = frame_bits(c0_q.size);
    assign fmask = frame_mask(nbits);
    assign half  = half_period(pre_q, c0_q.rate);
    assign start = c1_q.en && !tx_empty && eng_idle;
    assign din   = c1_q.lbm ? dout : spi_miso;

    assign ror_set = rx_valid && rx_full;
    assign clr_wr  = wr && (widx == IDX_IDENT);

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr && widx == IDX_DATA), .wdata(bus_wdata & fmask),
        .pop(start), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_valid), .wdata(rx_frame & fmask),
        .pop(rd && widx == IDX_DATA), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    ssp_shifter #(.DW(DATA_W)) u_eng (
        .clk(clk), .rst(rst), .en(c1_q.en),
        .cpol(c0_q.cpol), .cpha(c0_q.cpha), .nbits(nbits), .half(half),
        .start(start), .tx_frame(tx_head), .din(din),
        .sck(spi_sck), .dout(dout), .busy(eng_busy), .idle(eng_idle),
        .rx_valid(rx_valid), .rx_frame(rx_frame)
    );

    assign spi_mosi = dout;

    assign rx_int  = c1_q.rie   && (rx_cnt >= CW'(FIFO_DEPTH / 2));
    assign tx_int  = c1_q.tie   && (tx_cnt <= CW'(FIFO_DEPTH / 2));
    assign ror_int = c1_q.rorie && ror_q;
    assign irq     = rx_int || tx_int || ror_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            c0_q  <= '0;
            c1_q  <= '0;
            pre_q <= '0;
            ror_q <= 1'b0;
        end else begin
            if (wr) begin
                case (widx)
                    IDX_CTRL0: c0_q  <= '{rate: bus_wdata[15:8], cpol: bus_wdata[7],
                                          cpha: bus_wdata[6], size: bus_wdata[3:0]};
                    IDX_CTRL1: c1_q  <= ctrl1_t'(bus_wdata[6:0]);
                    IDX_PRE:   pre_q <= bus_wdata[7:0];
                    default: ;
                endcase
            end
            if (ror_set)     ror_q <= 1'b1;
            else if (clr_wr) ror_q <= 1'b0;
        end
    end

    always_comb begin
        case (widx)
            IDX_CTRL0: bus_rdata = {c0_q.rate, c0_q.cpol, c0_q.cpha, 2'b00, c0_q.size};
            IDX_CTRL1: bus_rdata = {9'd0, c1_q};
            IDX_DATA:  bus_rdata = rx_empty ? 16'd0 : rx_head;
            IDX_STAT:  bus_rdata = {11'd0, eng_busy || !tx_empty, rx_full, !rx_empty,
                                    !tx_full, tx_empty};
            IDX_PRE:   bus_rdata = {8'd0, pre_q};
            IDX_IDENT: bus_rdata = {13'd0, ror_int, tx_int, rx_int};
            default:   bus_rdata = 16'd0;
        endcase
    end
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] rx_cnt,
    input logic          rx_valid,
    input logic          rx_full,
    input logic          ror_q,
    input logic          clr_wr,
    input logic          eng_busy,
    input logic          spi_sck,
    input logic          cpol,
    input logic          port_en,
    input logic          rx_int
);
    // R12: receive queue never exceeds its depth
    p_rx_bound_r12: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH));

    // R6: completion into a full queue raises the overrun flag
    p_ror_set_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full) |=> ror_q);

    // R7: a write to the identify address clears the flag
    p_ror_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !(rx_valid && rx_full)) |=> !ror_q);

    // R4: idle clock level follows polarity
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> (spi_sck == cpol));

    // R10: clearing enable stops the engine
    p_stop_r10: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> !eng_busy);

    // R8: rx interrupt only with at least half a queue
    p_rx_int_r8: assert property (@(posedge clk) disable iff (rst)
        rx_int |-> (rx_cnt >= CW'(DEPTH / 2)));
endmodule

bind ssp_top ssp_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rx_cnt(rx_cnt), .rx_valid(rx_valid),
    .rx_full(rx_full), .ror_q(ror_q), .clr_wr(clr_wr), .eng_busy(eng_busy),
    .spi_sck(spi_sck), .cpol(c0_q.cpol), .port_en(c1_q.en), .rx_int(rx_int)
);

// File: tb/test_ssp_top.sv
module test_ssp_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_C0 = 5'h00, A_C1 = 5'h04, A_DAT = 5'h08,
                           A_ST = 5'h0C, A_PRE = 5'h10, A_ID = 5'h14;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic spi_sck, spi_mosi, spi_miso, irq;
    logic force_en = 1'b0, force_val = 1'b0, miso_slave = 1'b0;

    int nchk = 0, nerr = 0;

    assign spi_miso = force_en ? force_val : miso_slave;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_top i_ssp_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    function automatic logic [15:0] fmask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic int exp_half(input int pre, input int rate);
        int hp;
        hp = (pre / 2 == 0) ? 1 : pre / 2;
        return hp * (rate + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(A_ST, s);
            if (!s[4]) return;
        end
    endtask

    // ---------------- bench slave model ----------------
    logic        slave_on = 1'b0;
    logic        prev_sck = 1'b0;
    logic        scpha = 1'b0;
    int          sn = 8, e = 0, sidx = 0, ncap = 0;
    logic [15:0] srx = '0;
    logic [15:0] sframe [0:7];
    logic [15:0] cap    [0:7];

    task automatic slave_init();
        prev_sck = spi_sck; e = 0; sidx = 0; ncap = 0; srx = '0;
        miso_slave = sframe[0][sn-1];
    endtask

    always @(negedge clk) begin
        int k;
        if (slave_on && spi_sck !== prev_sck) begin
            prev_sck = spi_sck;
            if (e[0] == scpha) srx = {srx[14:0], spi_mosi};
            k = scpha ? e / 2 : (e + 1) / 2;
            if (e == 2 * sn - 1) begin
                if (ncap < 8) cap[ncap] = srx & fmask(sn);
                ncap++; srx = '0; e = 0; k = 0;
                if (sidx < 7) sidx++;
            end else begin
                e++;
            end
            miso_slave = (k < sn) ? sframe[sidx][sn-1-k] : 1'b0;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] d, s;
        logic [15:0] txf [0:7];
        int seed_dummy, toggles, ivl_bad, last_t, t;
        logic p;

        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_ST, d);  chk("R1 status", d, 16'h0003);
        rd(A_C0, d);  chk("R1 ctrl0", d, 16'h0000);
        rd(A_C1, d);  chk("R1 ctrl1", d, 16'h0000);
        rd(A_ID, d);  chk("R1 ident", d, 16'h0000);
        chk("R1 sck", spi_sck, 1'b0);
        chk("R1 irq", irq, 1'b0);

        // R2 register readback
        wr(A_C0, 16'hA5FE); rd(A_C0, d); chk("R2 ctrl0", d, 16'hA5CE);
        wr(A_C1, 16'h0060); rd(A_C1, d); chk("R2 ctrl1", d, 16'h0060);
        wr(A_PRE, 16'h01FE); rd(A_PRE, d); chk("R2 prescale", d, 16'h00FE);
        wr(A_C1, 16'h0000);

        // R11 loopback ignores miso (held at 1)
        force_en = 1'b1; force_val = 1'b1;
        wr(A_C0, 16'h0007); wr(A_PRE, 16'h0002); wr(A_C1, 16'h0018);
        txf[0] = 16'h00; txf[1] = 16'hFF; txf[2] = 16'h5A; txf[3] = 16'h81;
        for (int i = 0; i < 4; i++) wr(A_DAT, txf[i] | 16'hFF00);
        wait_idle();
        for (int i = 0; i < 4; i++) begin
            rd(A_DAT, d); chk("R11 loopback data", d, txf[i]);
        end

        // R5 bit rate: prescale 6, rate 2, 4-bit frame
        wr(A_C0, 16'h0203); wr(A_PRE, 16'h0006);
        wr(A_DAT, 16'h0009);
        toggles = 0; ivl_bad = 0; last_t = -1; p = spi_sck;
        for (t = 0; t < 200; t++) begin
            @(negedge clk);
            if (spi_sck !== p) begin
                p = spi_sck;
                if (last_t >= 0 && (t - last_t) != exp_half(6, 2)) ivl_bad++;
                last_t = t; toggles++;
            end
        end
        chk("R5 edges per frame", toggles, 8);
        chk("R5 half period errors", ivl_bad, 0);
        rd(A_DAT, d); chk("R3 4-bit loop", d, 16'h0009);

        // R3/R4 all four clock modes with a bench slave, random widths and rates
        force_en = 1'b0;
        for (int m = 0; m < 4; m++) begin
            int rate, pre;
            slave_on = 1'b0;
            sn = $urandom_range(16, 4);
            scpha = m[0];
            rate = $urandom_range(3, 0);
            pre = 2 * $urandom_range(2, 1);
            wr(A_C1, 16'h0000);
            wr(A_C0, {8'(rate), m[1], m[0], 2'b00, 4'(sn - 1)});
            wr(A_PRE, 16'(pre));
            for (int i = 0; i < 8; i++) begin
                txf[i]    = 16'($urandom) & fmask(sn);
                sframe[i] = 16'($urandom) & fmask(sn);
            end
            @(posedge clk);
            slave_init();
            slave_on = 1'b1;
            wr(A_C1, 16'h0010);
            for (int i = 0; i < 5; i++) wr(A_DAT, txf[i] | ~fmask(sn));
            wait_idle();
            chk("R3 one rx frame per tx frame", ncap, 5);
            for (int i = 0; i < 5; i++) begin
                chk("R4 slave captured mosi", cap[i], txf[i]);
                rd(A_DAT, d); chk("R4 master captured miso", d, sframe[i]);
            end
            chk("R4 idle sck level", spi_sck, m[1]);
        end
        slave_on = 1'b0;
        force_en = 1'b1; force_val = 1'b0;

        // R6/R7 overrun
        wr(A_C1, 16'h0000); wr(A_C0, 16'h0007); wr(A_PRE, 16'h0002);
        wr(A_C1, 16'h001C);
        for (int i = 0; i < 8; i++) wr(A_DAT, 16'h20 + 16'(i));
        wait_idle();
        rd(A_ST, d); chk("R9 status rx full", d, 16'h000F);
        rd(A_ID, d); chk("R6 no overrun yet", d, 16'h0000);
        wr(A_DAT, 16'h00EE);
        wait_idle();
        rd(A_ID, d); chk("R6 overrun flag", d, 16'h0004);
        chk("R8 irq from overrun", irq, 1'b1);
        wr(A_ID, 16'h5A5A);
        rd(A_ID, d); chk("R7 overrun cleared", d, 16'h0000);
        chk("R7 irq low", irq, 1'b0);
        for (int i = 0; i < 8; i++) begin
            rd(A_DAT, d); chk("R6 queue kept", d, 16'h20 + 16'(i));
        end

        // R8/R9/R10/R12 thresholds with the port disabled
        wr(A_C1, 16'h0003);
        rd(A_ID, d); chk("R8 tx int empty", d, 16'h0002);
        for (int i = 0; i < 4; i++) wr(A_DAT, 16'h10 + 16'(i));
        rd(A_ID, d); chk("R8 tx int at 4", d, 16'h0002);
        chk("R8 irq tx", irq, 1'b1);
        wr(A_DAT, 16'h14);
        rd(A_ID, d); chk("R8 tx int at 5", d, 16'h0000);
        chk("R8 irq off", irq, 1'b0);
        for (int i = 5; i < 8; i++) wr(A_DAT, 16'h10 + 16'(i));
        rd(A_ST, d); chk("R9 status tx full", d, 16'h0010);
        wr(A_DAT, 16'h0099);
        toggles = 0; p = spi_sck;
        repeat (60) begin
            @(negedge clk);
            if (spi_sck !== p) begin p = spi_sck; toggles++; end
        end
        chk("R10 no sck while disabled", toggles, 0);
        rd(A_ST, s); chk("R10 frames held", s, 16'h0010);
        wr(A_C1, 16'h001B);
        wait_idle();
        rd(A_ST, d); chk("R9 status after drain", d, 16'h000F);
        rd(A_ID, d); chk("R8 rx and tx int", d, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            rd(A_DAT, d); chk("R12 order", d, 16'h10 + 16'(i));
        end
        rd(A_ID, d); chk("R8 rx int at 4", d[0], 1'b1);
        rd(A_DAT, d); chk("R12 order", d, 16'h14);
        rd(A_ID, d); chk("R8 rx int at 3", d[0], 1'b0);
        for (int i = 5; i < 8; i++) begin
            rd(A_DAT, d); chk("R12 order", d, 16'h10 + 16'(i));
        end
        rd(A_ST, d); chk("R12 ninth frame dropped", d, 16'h0003);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule